// File: doc/BRIEF.md
# Breakdown Pulse Window Recorder

This block records the filtered I/Q waveform of every RF pulse into an on-chip ring of pulse-sized slots. Recording runs continuously at the repetition rate. A breakdown flag marks the pulse in which the fault was seen. Once that flag is seen, the recorder lets one further pulse be written and then stops writing. At that point it holds a five-pulse window: three pulses of history, the faulted pulse, and the pulse that followed it.

The window is read out in time order through a simple request port. Each word carries its position in the window and its sample index within the pulse, so host software can rebuild the waveforms without knowing where they sat in the ring.

Incoming samples pass through a small FIFO. The pulse-start and breakdown markers travel through it in the same word as their sample. A host acknowledge releases the frozen window and recording resumes.

Top module: `pulse_event_recorder`

## Requirements
- R1: After reset `captureReady`, `overflowFlag`, `rdValid` and `readDone` are all 0.
- R2: A sample is taken when `sampleValid` is 1. `pulseStart` and `breakdown` count only on such a sample. A sample with `pulseStart` set opens a new pulse in the next slot of a ring of `NUM_SLOTS` (at least 6) slots. Later samples fill that slot from index 0 upward. Samples that arrive before the first `pulseStart` after reset or after an acknowledge are discarded.
- R3: A captured window is read out in a fixed order. Positions 0, 1 and 2 are the three recorded pulses before the breakdown pulse, oldest first. Position 3 is the breakdown pulse and position 4 is the pulse recorded right after it. Each sample comes back with the value it was written with.
- R4: `captureReady` rises when the `pulseStart` that follows the start of the post-breakdown pulse is processed. That new pulse is not recorded. `captureReady` then stays high until an acknowledge.
- R5: While `captureReady` is 1 and `rdReq` is 1, the read logic steps once per cycle. A read word appears with `rdValid` one cycle after its step. Within a pulse `rdSample` counts 0, 1, 2 and so on, and `rdPos` never decreases. Exactly the stored samples of each of the five pulses are returned, and then `readDone` goes to 1.
- R6: A `breakdown` flag is ignored from the moment a capture starts until it is acknowledged. While `captureReady` is 1, incoming samples leave the stored window unchanged.
- R7: `ackIn` while `captureReady` is 1 clears `captureReady` on the next cycle. Recording restarts with the next `pulseStart`.
- R8: Samples beyond `SLOT_DEPTH` in one pulse are dropped and set `overflowFlag`. The flag stays set until reset. A pulse of exactly `SLOT_DEPTH` samples does not set it.
- R9: A breakdown belongs to the pulse that contains the flagged sample. A flag on a `pulseStart` sample marks the new pulse. A flag on a sample outside any pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies the sample and its markers |
| sampleData | input | DATA_W | Filtered I/Q sample word |
| pulseStart | input | 1 | This sample is the first of a new pulse |
| breakdown | input | 1 | A breakdown was detected in the pulse of this sample |
| ackIn | input | 1 | Host releases the frozen window |
| rdReq | input | 1 | Host requests read steps |
| rdValid | output | 1 | Read word valid |
| rdData | output | DATA_W | Stored sample |
| rdPos | output | 3 | Window position 0..4 of the word |
| rdSample | output | $clog2(SLOT_DEPTH+1) | Sample index within the pulse |
| readDone | output | 1 | All five pulses have been returned |
| captureReady | output | 1 | A window is frozen and readable |
| overflowFlag | output | 1 | Sticky: some pulse was truncated |

## Verification
The assertions check the following on every cycle:
- `captureReady` holds until acknowledged and drops right after the acknowledge.
- Read words appear only while a window is frozen, and their position and sample fields stay in range.
- Words within a readout come in ascending order.
- The overflow flag never clears by itself.

The bench scenarios cover what the assertions cannot see:
- Which pulses end up in the window, and the exact sample values and lengths returned.
- That the breakdown flags and samples that arrive during a pending or frozen capture, and stray samples outside a pulse, really leave the stored data untouched.
- That a pulse of exactly slot size does not set the overflow flag.

// File: rtl/pulse_rec_pkg.sv
package pulse_rec_pkg;
  localparam int PRE_PULSES     = 3;
  localparam int CAPTURE_PULSES = 5;
  localparam int POS_W          = 3;

  typedef enum logic [1:0] {
    ST_RUN,     // recording, no event pending
    ST_EVENT,   // breakdown pulse in progress
    ST_POST,    // post-event pulse in progress
    ST_FROZEN   // window held for readout
  } recState_t;

  typedef struct packed {
    logic advance;      // popped sample opens a new pulse slot
    logic store;        // popped sample is to be recorded
    logic markEvent;    // latch the breakdown slot
    logic readStep;     // advance the readout sequencer
    logic readRestart;  // rewind the readout sequencer
  } recStrobes_t;
endpackage

// File: rtl/rec_fifo.sv
module rec_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  output logic             popValid,
  output logic [WIDTH-1:0] popData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             pushOk;

  // The consumer drains one entry every cycle the FIFO is not empty.
  assign popValid = (count != '0);
  assign popData  = store[rdPtr];
  assign pushOk   = pushEn && (count != CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (pushOk) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (popValid) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(pushOk) - CNT_W'(popValid);
    end
  end
endmodule

// File: rtl/rec_ctrl.sv
module rec_ctrl
  import pulse_rec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        popValid,
  input  logic        popStart,
  input  logic        popBd,
  input  logic        ackIn,
  input  logic        rdReq,
  input  logic        drained,
  output recStrobes_t strobes,
  output logic        captureReady,
  output logic        readDone
);
  recState_t state, nextState;
  logic      inPulse, nextInPulse;

  always_comb begin
    strobes     = '0;
    nextState   = state;
    nextInPulse = inPulse;
    case (state)
      ST_RUN, ST_EVENT, ST_POST: begin
        if (popValid) begin
          if (state == ST_POST && popStart) begin
            // the post-event pulse has ended: freeze the window
            nextState           = ST_FROZEN;
            strobes.readRestart = 1'b1;
          end else begin
            strobes.advance = popStart;
            strobes.store   = popStart || inPulse;
            if (popStart) nextInPulse = 1'b1;
            if (state == ST_RUN && popBd && (popStart || inPulse)) begin
              strobes.markEvent = 1'b1;
              nextState         = ST_EVENT;
            end else if (state == ST_EVENT && popStart) begin
              nextState = ST_POST;
            end
          end
        end
      end
      ST_FROZEN: begin
        strobes.readStep = rdReq && !drained;
        if (ackIn) begin
          nextState   = ST_RUN;
          nextInPulse = 1'b0;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      inPulse <= 1'b0;
    end else begin
      state   <= nextState;
      inPulse <= nextInPulse;
    end
  end

  assign captureReady = (state == ST_FROZEN);
  assign readDone     = captureReady && drained;
endmodule

// File: rtl/rec_datapath.sv
module rec_datapath
  import pulse_rec_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_SLOTS  = 8,
  parameter int SLOT_DEPTH = 64,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W     = $clog2(SLOT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              pulseStart,
  input  logic              breakdown,
  input  recStrobes_t       strobes,
  output logic              popValid,
  output logic              popStart,
  output logic              popBd,
  output logic              drained,
  output logic              overflowFlag,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [POS_W-1:0]  rdPos,
  output logic [CNT_W-1:0]  rdSample
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int WORDS  = NUM_SLOTS * SLOT_DEPTH;
  localparam int ADDR_W = $clog2(WORDS);
  localparam int FW     = DATA_W + 2;

  // input FIFO: markers travel with their sample
  logic [FW-1:0]     popWord;
  logic [DATA_W-1:0] popSample;

  rec_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (sampleValid),
    .pushData ({pulseStart, breakdown, sampleData}),
    .popValid (popValid),
    .popData  (popWord)
  );
  assign {popStart, popBd, popSample} = popWord;

  logic [DATA_W-1:0] mem [WORDS];
  logic [CNT_W-1:0]  lenTab [NUM_SLOTS];
  logic [SLOT_W-1:0] wrSlot, nextSlot, wrTarget, evtSlot, curSlot;
  logic [CNT_W-1:0]  wrIdx, wrOffset, curLen, rdIdxQ;
  logic [POS_W-1:0]  rdPosQ;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              room, writeNow, readHit;

  function automatic logic [ADDR_W-1:0] slotAddr(input logic [SLOT_W-1:0] s,
                                                 input logic [CNT_W-1:0] off);
    return ADDR_W'(int'(s) * SLOT_DEPTH + int'(off));
  endfunction

  // write side
  assign nextSlot = (wrSlot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : wrSlot + SLOT_W'(1);
  assign wrTarget = strobes.advance ? nextSlot : wrSlot;
  assign wrOffset = strobes.advance ? '0 : wrIdx;
  assign room     = strobes.advance || (wrIdx < CNT_W'(SLOT_DEPTH));
  assign writeNow = strobes.store && room;
  assign wrAddr   = slotAddr(wrTarget, wrOffset);

  // read side: window position -> ring slot, oldest first
  always_comb begin
    int t;
    t       = int'(evtSlot) + NUM_SLOTS - PRE_PULSES + int'(rdPosQ);
    curSlot = SLOT_W'(t % NUM_SLOTS);
  end
  assign curLen  = lenTab[curSlot];
  assign drained = (rdPosQ == POS_W'(CAPTURE_PULSES));
  assign readHit = strobes.readStep && !drained && (rdIdxQ < curLen);
  assign rdAddr  = slotAddr(curSlot, rdIdxQ);

  always_ff @(posedge clk) begin
    if (writeNow) mem[wrAddr] <= popSample;
    if (readHit)  rdData      <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSlot       <= SLOT_W'(NUM_SLOTS - 1);
      wrIdx        <= '0;
      evtSlot      <= '0;
      overflowFlag <= 1'b0;
      rdPosQ       <= '0;
      rdIdxQ       <= '0;
      rdValid      <= 1'b0;
      rdPos        <= '0;
      rdSample     <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) lenTab[i] <= '0;
    end else begin
      if (strobes.advance) wrSlot <= nextSlot;
      if (writeNow) begin
        wrIdx            <= wrOffset + CNT_W'(1);
        lenTab[wrTarget] <= wrOffset + CNT_W'(1);
      end else if (strobes.store) begin
        overflowFlag <= 1'b1;
      end
      if (strobes.markEvent) evtSlot <= wrTarget;

      if (strobes.readRestart) begin
        rdPosQ <= '0;
        rdIdxQ <= '0;
      end else if (strobes.readStep && !drained) begin
        if (readHit) begin
          rdIdxQ <= rdIdxQ + CNT_W'(1);
        end else begin
          rdPosQ <= rdPosQ + POS_W'(1);
          rdIdxQ <= '0;
        end
      end

      rdValid <= readHit;
      if (readHit) begin
        rdPos    <= rdPosQ;
        rdSample <= rdIdxQ;
      end
    end
  end
endmodule

// File: rtl/pulse_event_recorder.sv
module pulse_event_recorder
  import pulse_rec_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_SLOTS  = 8,
  parameter int SLOT_DEPTH = 64,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sampleValid,
  input  logic [DATA_W-1:0]                sampleData,
  input  logic                             pulseStart,
  input  logic                             breakdown,
  input  logic                             ackIn,
  input  logic                             rdReq,
  output logic                             rdValid,
  output logic [DATA_W-1:0]                rdData,
  output logic [2:0]                       rdPos,
  output logic [$clog2(SLOT_DEPTH+1)-1:0]  rdSample,
  output logic                             readDone,
  output logic                             captureReady,
  output logic                             overflowFlag
);
  recStrobes_t strobes;
  logic popValid, popStart, popBd, drained;

  rec_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .popValid     (popValid),
    .popStart     (popStart),
    .popBd        (popBd),
    .ackIn        (ackIn),
    .rdReq        (rdReq),
    .drained      (drained),
    .strobes      (strobes),
    .captureReady (captureReady),
    .readDone     (readDone)
  );

  rec_datapath #(
    .DATA_W     (DATA_W),
    .NUM_SLOTS  (NUM_SLOTS),
    .SLOT_DEPTH (SLOT_DEPTH),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .sampleData   (sampleData),
    .pulseStart   (pulseStart),
    .breakdown    (breakdown),
    .strobes      (strobes),
    .popValid     (popValid),
    .popStart     (popStart),
    .popBd        (popBd),
    .drained      (drained),
    .overflowFlag (overflowFlag),
    .rdValid      (rdValid),
    .rdData       (rdData),
    .rdPos        (rdPos),
    .rdSample     (rdSample)
  );
endmodule

// File: rtl/pulse_event_recorder_checker.sv
module pulse_event_recorder_checker #(
  parameter int SLOT_DEPTH = 64,
  localparam int CNT_W     = $clog2(SLOT_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             ackIn,
  input logic             rdValid,
  input logic [2:0]       rdPos,
  input logic [CNT_W-1:0] rdSample,
  input logic             captureReady,
  input logic             overflowFlag
);
  logic [2:0]       lastPos;
  logic [CNT_W-1:0] lastSample;
  logic             seen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastPos    <= '0;
      lastSample <= '0;
      seen       <= 1'b0;
    end else if (rdValid) begin
      lastPos    <= rdPos;
      lastSample <= rdSample;
      seen       <= 1'b1;
    end else if (!captureReady) begin
      seen <= 1'b0;
    end
  end

  assert_ready_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    captureReady && !ackIn |=> captureReady);

  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    captureReady && ackIn |=> !captureReady);

  assert_read_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(captureReady));

  assert_word_fields_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdPos < 3'd5) && (rdSample < CNT_W'(SLOT_DEPTH)));

  assert_word_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && seen |-> (rdPos > lastPos) ||
                        ((rdPos == lastPos) && (rdSample == lastSample + CNT_W'(1))));

  assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);
endmodule

bind pulse_event_recorder pulse_event_recorder_checker #(.SLOT_DEPTH(SLOT_DEPTH)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .ackIn        (ackIn),
  .rdValid      (rdValid),
  .rdPos        (rdPos),
  .rdSample     (rdSample),
  .captureReady (captureReady),
  .overflowFlag (overflowFlag)
);

// File: tb/test_pulse_event_recorder.sv
`timescale 1ns/1ps
module test_pulse_event_recorder;
  localparam int DATA_W     = 16;
  localparam int NUM_SLOTS  = 6;
  localparam int SLOT_DEPTH = 4;
  localparam int CNT_W      = $clog2(SLOT_DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic              pulseStart = 1'b0;
  logic              breakdown = 1'b0;
  logic              ackIn = 1'b0;
  logic              rdReq = 1'b0;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;
  logic [2:0]        rdPos;
  logic [CNT_W-1:0]  rdSample;
  logic              readDone, captureReady, overflowFlag;

  always #2.5 clk = ~clk;

  pulse_event_recorder #(
    .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_DEPTH(SLOT_DEPTH), .FIFO_DEPTH(4)
  ) i_pulse_event_recorder (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .pulseStart(pulseStart), .breakdown(breakdown), .ackIn(ackIn), .rdReq(rdReq),
    .rdValid(rdValid), .rdData(rdData), .rdPos(rdPos), .rdSample(rdSample),
    .readDone(readDone), .captureReady(captureReady), .overflowFlag(overflowFlag)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int pid = 0;
  int recList [64];
  int recCount = 0;
  bit expectOvf = 1'b0;

  task automatic check(string req, int actual, int expected, string what);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  function automatic int pulseLen(int p);
    return (p < 3) ? 3 : 1 + ((p * 5) % 6);
  endfunction

  function automatic int sampleVal(int p, int i);
    return ((p & 255) << 8) | (i & 255);
  endfunction

  // one pulse: pulseStart on sample 0, breakdown on sample bdAt (-1 = none)
  task automatic sendPulse(int bdAt, bit recorded);
    int len;
    len = pulseLen(pid);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      pulseStart  = (i == 0);
      breakdown   = (i == bdAt);
      sampleData  = DATA_W'(sampleVal(pid, i));
    end
    @(negedge clk);
    sampleValid = 1'b0;
    pulseStart  = 1'b0;
    breakdown   = 1'b0;
    @(negedge clk);
    if (recorded) begin
      recList[recCount] = pid;
      recCount++;
      if (len > SLOT_DEPTH) expectOvf = 1'b1;
      check("R8", int'(overflowFlag), int'(expectOvf), $sformatf("overflow after pulse len %0d", len));
    end
    pid++;
  endtask

  task automatic readCapture(int evtIdx);
    int ePos [24];
    int eSmp [24];
    int eDat [24];
    int expCount = 0;
    int got = 0;
    for (int p = 0; p < 5; p++) begin
      int id;
      int l;
      id = recList[evtIdx - 3 + p];
      l  = (pulseLen(id) > SLOT_DEPTH) ? SLOT_DEPTH : pulseLen(id);
      for (int i = 0; i < l; i++) begin
        ePos[expCount] = p;
        eSmp[expCount] = i;
        eDat[expCount] = sampleVal(id, i);
        expCount++;
      end
    end
    @(negedge clk);
    rdReq = 1'b1;
    for (int guard = 0; guard < 200; guard++) begin
      @(negedge clk);
      if (rdValid) begin
        if (got < expCount) begin
          check("R3", int'(rdPos), ePos[got], "window position");
          check("R5", int'(rdSample), eSmp[got], "sample index");
          check("R3", int'(rdData), eDat[got], "sample value");
        end
        got++;
      end
      if (readDone && !rdValid) break;
    end
    rdReq = 1'b0;
    check("R5", got, expCount, "word count");
    check("R5", int'(readDone), 1, "readDone after window");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", int'(captureReady), 0, "captureReady");
    check("R1", int'(overflowFlag), 0, "overflowFlag");
    check("R1", int'(rdValid), 0, "rdValid");
    check("R1", int'(readDone), 0, "readDone");

    for (int r = 0; r < 6; r++) begin
      int nPre;
      int evtIdx;
      nPre = (r % 2 == 0) ? 4 : 2;
      if (r == 3) begin
        // R9: flagged samples outside any pulse are discarded and ignored
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          sampleValid = 1'b1;
          breakdown   = 1'b1;
          sampleData  = DATA_W'(16'hEEEE);
        end
        @(negedge clk);
        sampleValid = 1'b0;
        breakdown   = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", int'(captureReady), 0, "stray flag outside pulse");
      end
      // R2: continuous recording of history pulses
      for (int k = 0; k < nPre; k++) sendPulse(-1, 1'b1);
      // R9: breakdown on sample r mod len (sample 0 is the pulse-start sample)
      sendPulse(r % pulseLen(pid), 1'b1);
      evtIdx = recCount - 1;
      // R6: breakdown during the post pulse is ignored
      sendPulse(0, 1'b1);
      check("R4", int'(captureReady), 0, "not ready before post pulse ends");
      // R4: next start freezes; this pulse is not recorded
      sendPulse(1, 1'b0);
      repeat (2) @(negedge clk);
      check("R4", int'(captureReady), 1, "ready after post pulse");
      // R6: samples and flags while frozen leave the window unchanged
      sendPulse(0, 1'b0);
      check("R6", int'(captureReady), 1, "still frozen");
      readCapture(evtIdx);
      // R7: acknowledge releases the window
      @(negedge clk);
      ackIn = 1'b1;
      @(negedge clk);
      ackIn = 1'b0;
      check("R7", int'(captureReady), 0, "released after ack");
      check("R7", int'(readDone), 0, "readDone cleared after ack");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule